// File: doc/BRIEF.md
# Inter-Processor Attention and Acknowledge Interrupt Unit

This block couples a host processor and one auxiliary processor that share a chassis. Interrupts pass between them through two independent handshakes running in opposite directions. In the first, the host posts a request that interrupts the auxiliary, and the auxiliary answers with an acknowledge that interrupts the host. In the second, the auxiliary posts an attention that interrupts the host, and the host answers by setting an acknowledge bit that interrupts the auxiliary. The board in the first slot takes the host port. That choice is made outside this block, and only the port assignment reflects it.

Each side has a write port and a read port. A write carries command bits: originate a message, acknowledge a message, clear one of the two flags that interrupt this side, and load the enable for the far side's interrupt. Each of the four pending flags is level-held until the receiving side clears it. Each side's interrupt output is the OR of its two incoming flags, gated by an enable bit. The far processor owns that enable bit, and clearing it does not drop any pending state. Both read ports return the same status word.

Top module: `ipi_handshake_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four pending flags clear. The auxiliary-interrupt enable loads `AUX_EN_RST` and the host-interrupt enable loads `HOST_EN_RST`, so both interrupt outputs are low after reset.
- R2: A host write with bit 0 set raises the host-request flag after that clock edge. The flag shows at status bit 0.
- R3: An auxiliary write with bit 1 set raises the request-acknowledge flag after that edge. The flag shows at status bit 1.
- R4: An auxiliary write with bit 0 set raises the attention flag after that edge. The flag shows at status bit 2.
- R5: A host write with bit 1 set raises the attention-acknowledge flag after that edge. The flag shows at status bit 3.
- R6: A flag holds until its receiving side writes the matching clear bit. For the host, bit 2 clears attention and bit 3 clears request-acknowledge. For the auxiliary, bit 2 clears host-request and bit 3 clears attention-acknowledge. No other write clears a flag.
- R7: When a flag is set and cleared in the same cycle, from either port or both, the flag ends up set.
- R8: A write with bit 4 set loads bit 5 into the enable for the far side's interrupt. The host loads the auxiliary enable (status bit 4) and the auxiliary loads the host enable (status bit 5). A masked flag stays pending and drives its output again once the enable returns.
- R9: `h_irq` equals (request-acknowledge OR attention) AND host enable. `a_irq` equals (host-request OR attention-acknowledge) AND auxiliary enable. Both follow the registered state in the same cycle as the status.
- R10: Both read ports return the same status word, and bits above 5 read zero. The block ignores a write with its enable low, and it ignores write bits 6 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr_en | input | 1 | Host write strobe |
| h_wr_data | input | DATA_W | Host command bits |
| h_rd_data | output | DATA_W | Status seen by the host |
| h_irq | output | 1 | Interrupt to the host |
| a_wr_en | input | 1 | Auxiliary write strobe |
| a_wr_data | input | DATA_W | Auxiliary command bits |
| a_rd_data | output | DATA_W | Status seen by the auxiliary |
| a_irq | output | 1 | Interrupt to the auxiliary |

## Verification
The bench builds the block with `DATA_W` = 8, `AUX_EN_RST` = 1 and `HOST_EN_RST` = 0. The two enables therefore leave reset in opposite states. This means a flag can pend behind a closed enable from the very first write and is released later by a mask write from the far side. An 8-bit bus leaves two spare command bits, which lets the bench check that the block ignores them. The random phase drives both ports in the same cycle often enough to hit cross-port set and clear collisions on every flag.

// File: rtl/ipi_pkg.sv
// Shared constants for the inter-processor interrupt unit.
// Assumes both ports use the same command bit layout; only the flag each
// bit targets differs with the port's role.
package ipi_pkg;
    localparam int NUM_FLAGS = 4;
    localparam int STAT_W    = 6;

    // Pending flag indices, equal to their status bit positions.
    localparam int F_HREQ = 0;   // host request, interrupts auxiliary
    localparam int F_RACK = 1;   // auxiliary acknowledge, interrupts host
    localparam int F_ATTN = 2;   // auxiliary attention, interrupts host
    localparam int F_AACK = 3;   // host acknowledge, interrupts auxiliary

    // Status positions of the two enables.
    localparam int S_AUX_EN  = 4;
    localparam int S_HOST_EN = 5;

    // Command bit positions on either write port.
    localparam int C_ORIG   = 0;  // originate a message to the far side
    localparam int C_ACK    = 1;  // acknowledge the far side's message
    localparam int C_CLR_M  = 2;  // clear the far side's message flag
    localparam int C_CLR_A  = 3;  // clear the far side's acknowledge flag
    localparam int C_MSK_WE = 4;  // load the far side's interrupt enable
    localparam int C_MSK_V  = 5;  // value for that enable

    typedef enum logic {ROLE_HOST = 1'b0, ROLE_AUX = 1'b1} role_e;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] set;
        logic [NUM_FLAGS-1:0] clr;
        logic                 mask_we;
        logic                 mask_val;
    } cmd_t;
endpackage

// File: rtl/ipi_cmd_decode.sv
// Turns one port's write into per-flag set and clear strobes and an
// enable load. The ROLE parameter selects the flag each command bit reaches.
// Assumes DATA_W >= 6; bits above 5 are ignored.
module ipi_cmd_decode
    import ipi_pkg::*;
#(
    parameter int    DATA_W = 16,
    parameter role_e ROLE   = ROLE_HOST
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output cmd_t              cmd
);
    generate
        if (ROLE == ROLE_HOST) begin : g_host
            // Host: originates request and attention-ack, clears attention and request-ack.
            always_comb begin
                cmd          = '0;
                cmd.set[F_HREQ] = wr_en & wr_data[C_ORIG];
                cmd.set[F_AACK] = wr_en & wr_data[C_ACK];
                cmd.clr[F_ATTN] = wr_en & wr_data[C_CLR_M];
                cmd.clr[F_RACK] = wr_en & wr_data[C_CLR_A];
                cmd.mask_we     = wr_en & wr_data[C_MSK_WE];
                cmd.mask_val    = wr_data[C_MSK_V];
            end
        end else begin : g_aux
            // Auxiliary: originates attention and request-ack, clears request and attention-ack.
            always_comb begin
                cmd          = '0;
                cmd.set[F_ATTN] = wr_en & wr_data[C_ORIG];
                cmd.set[F_RACK] = wr_en & wr_data[C_ACK];
                cmd.clr[F_HREQ] = wr_en & wr_data[C_CLR_M];
                cmd.clr[F_AACK] = wr_en & wr_data[C_CLR_A];
                cmd.mask_we     = wr_en & wr_data[C_MSK_WE];
                cmd.mask_val    = wr_data[C_MSK_V];
            end
        end
    endgenerate
endmodule

// File: rtl/ipi_pend_flag.sv
// One level-held pending flag. Set has priority over clear.
// Assumes set and clr are already qualified by the write strobe.
module ipi_pend_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag; set beats clear; synchronous reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);                                                    // R7
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(q));                               // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);                                         // R6
endmodule

// File: rtl/ipi_mask_reg.sv
// Interrupt enable bit for one side, written only by the far side.
// Assumes RST_VAL is the enable state wanted after reset.
module ipi_mask_reg #(
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic val,
    output logic en
);
    // Load the enable on a mask write; reset to RST_VAL.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= RST_VAL;
        else if (we) en <= val;
    end

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(en));                                          // R8
endmodule

// File: rtl/ipi_handshake_unit.sv
// Two opposite-direction interrupt handshakes between a host and one
// auxiliary processor. Each side writes commands and reads a shared status.
// Assumes both ports share clk and that the host port is wired to the
// first-slot board.
module ipi_handshake_unit
    import ipi_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter bit AUX_EN_RST  = 1'b1,
    parameter bit HOST_EN_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_wr_en,
    input  logic [DATA_W-1:0] h_wr_data,
    output logic [DATA_W-1:0] h_rd_data,
    output logic              h_irq,
    input  logic              a_wr_en,
    input  logic [DATA_W-1:0] a_wr_data,
    output logic [DATA_W-1:0] a_rd_data,
    output logic              a_irq
);
    localparam int PAD_W = DATA_W - STAT_W;

    cmd_t                 h_cmd, a_cmd;
    logic [NUM_FLAGS-1:0] pend;
    logic                 aux_en, host_en;
    logic [STAT_W-1:0]    status;

    ipi_cmd_decode #(.DATA_W(DATA_W), .ROLE(ROLE_HOST)) u_hdec (
        .wr_en(h_wr_en), .wr_data(h_wr_data), .cmd(h_cmd));
    ipi_cmd_decode #(.DATA_W(DATA_W), .ROLE(ROLE_AUX)) u_adec (
        .wr_en(a_wr_en), .wr_data(a_wr_data), .cmd(a_cmd));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
            ipi_pend_flag u_flag (
                .clk(clk), .rst_n(rst_n),
                .set(h_cmd.set[gi] | a_cmd.set[gi]),
                .clr(h_cmd.clr[gi] | a_cmd.clr[gi]),
                .q(pend[gi]));
        end
    endgenerate

    // Host writes the auxiliary's enable; auxiliary writes the host's.
    ipi_mask_reg #(.RST_VAL(AUX_EN_RST)) u_aux_mask (
        .clk(clk), .rst_n(rst_n), .we(h_cmd.mask_we), .val(h_cmd.mask_val), .en(aux_en));
    ipi_mask_reg #(.RST_VAL(HOST_EN_RST)) u_host_mask (
        .clk(clk), .rst_n(rst_n), .we(a_cmd.mask_we), .val(a_cmd.mask_val), .en(host_en));

    // Assemble the status word and gate each side's interrupt.
    always_comb begin
        status = {host_en, aux_en, pend};
        h_irq  = (pend[F_RACK] | pend[F_ATTN]) & host_en;
        a_irq  = (pend[F_HREQ] | pend[F_AACK]) & aux_en;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign h_rd_data = {{PAD_W{1'b0}}, status};
            assign a_rd_data = {{PAD_W{1'b0}}, status};
        end else begin : g_nopad
            assign h_rd_data = status;
            assign a_rd_data = status;
        end
    endgenerate

    AST_HOST_REQ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_en && h_wr_data[C_ORIG]) |=> a_rd_data[F_HREQ]);        // R2
    AST_AUX_ACK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_wr_data[C_ACK]) |=> h_rd_data[F_RACK]);         // R3
    AST_ATTN_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr_en && a_wr_data[C_ORIG]) |=> h_rd_data[F_ATTN]);        // R4
    AST_HOST_ACK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr_en && h_wr_data[C_ACK]) |=> a_rd_data[F_AACK]);         // R5
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_wr_en && !a_wr_en) |=> $stable(h_rd_data));               // R10
endmodule

// File: tb/ipi_handshake_unit_test.sv
module ipi_handshake_unit_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          h_wr_en = 1'b0, a_wr_en = 1'b0;
    logic [DW-1:0] h_wr_data = '0, a_wr_data = '0;
    logic [DW-1:0] h_rd_data, a_rd_data;
    logic          h_irq, a_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model: [0] host-req, [1] req-ack, [2] attention, [3] attn-ack.
    logic [3:0] m_pend;
    logic       m_aen, m_hen;

    ipi_handshake_unit #(.DATA_W(DW), .AUX_EN_RST(1'b1), .HOST_EN_RST(1'b0)) uut (
        .clk(clk), .rst_n(rst_n),
        .h_wr_en(h_wr_en), .h_wr_data(h_wr_data), .h_rd_data(h_rd_data), .h_irq(h_irq),
        .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_rd_data(a_rd_data), .a_irq(a_irq));

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] exp_status();
        return {2'b00, m_hen, m_aen, m_pend};
    endfunction

    function automatic logic exp_hirq();
        return (m_pend[1] | m_pend[2]) & m_hen;
    endfunction

    function automatic logic exp_airq();
        return (m_pend[0] | m_pend[3]) & m_aen;
    endfunction

    // Next-state model from the requirement text.
    task automatic model_step(input logic hw, input logic [DW-1:0] hd,
                              input logic aw, input logic [DW-1:0] ad);
        logic [3:0] s, c;
        s = '0; c = '0;
        if (hw) begin
            s[0] = hd[0]; s[3] = hd[1]; c[2] = hd[2]; c[1] = hd[3];
        end
        if (aw) begin
            s[2] = s[2] | ad[0]; s[1] = s[1] | ad[1];
            c[0] = c[0] | ad[2]; c[3] = c[3] | ad[3];
        end
        m_pend = s | (m_pend & ~c);
        if (hw && hd[4]) m_aen = hd[5];
        if (aw && ad[4]) m_hen = ad[5];
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, {24'd0, h_rd_data}, {24'd0, exp_status()});
        check("R10", {24'd0, a_rd_data}, {24'd0, exp_status()});
        check("R9", {31'd0, h_irq}, {31'd0, exp_hirq()});
        check("R9", {31'd0, a_irq}, {31'd0, exp_airq()});
    endtask

    // One cycle: drive away from the edge, clock, update model, sample.
    task automatic step(input logic hw, input logic [DW-1:0] hd,
                        input logic aw, input logic [DW-1:0] ad, input string tag);
        h_wr_en = hw; h_wr_data = hd; a_wr_en = aw; a_wr_data = ad;
        @(posedge clk); #2;
        model_step(hw, hd, aw, ad);
        h_wr_en = 1'b0; a_wr_en = 1'b0;
        check_all(tag);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'h1a2b);
        m_pend = '0; m_aen = 1'b1; m_hen = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check_all("R1");
        check("R1", {31'd0, h_irq | a_irq}, 32'd0);
        rst_n = 1'b1;

        step(1, 8'h01, 0, 8'h00, "R2");         // host request
        check("R2", {31'd0, a_irq}, 32'd1);
        step(0, 8'h00, 1, 8'h02, "R3");         // aux ack, host masked
        check("R8", {31'd0, h_irq}, 32'd0);
        step(0, 8'h00, 1, 8'h30, "R8");         // aux opens host enable
        check("R8", {31'd0, h_irq}, 32'd1);
        step(0, 8'h00, 1, 8'h01, "R4");         // attention
        step(1, 8'h02, 0, 8'h00, "R5");         // host attention ack
        step(0, 8'h00, 1, 8'h08, "R6");         // aux clears attn-ack only
        step(1, 8'h08, 0, 8'h00, "R6");         // host clears req-ack
        step(1, 8'h0F, 0, 8'h0F, "R10");        // both strobes low below?
        step(0, 8'h0F, 0, 8'h0F, "R10");        // enables low: ignored
        step(1, 8'hC0, 1, 8'hC0, "R10");        // spare bits ignored
        step(1, 8'h01, 1, 8'h04, "R7");         // set req vs clear req
        check("R7", {31'd0, a_rd_data[0]}, 32'd1);
        step(1, 8'h02, 1, 8'h08, "R7");         // set attn-ack vs clear
        step(1, 8'h10, 0, 8'h00, "R8");         // host masks aux
        check("R8", {31'd0, a_irq}, 32'd0);
        step(1, 8'h30, 0, 8'h00, "R8");         // pending returns
        check("R8", {31'd0, a_irq}, 32'd1);
        step(1, 8'h0C, 1, 8'h0C, "R6");         // both clear everything

        for (int i = 0; i < 3000; i++) begin
            logic [DW-1:0] hd, ad;
            logic hw, aw;
            hw = ($urandom % 3) != 0;
            aw = ($urandom % 3) != 0;
            hd = DW'($urandom);
            ad = DW'($urandom);
            if (($urandom % 4) != 0) begin hd[4] = 1'b0; ad[4] = 1'b0; end
            step(hw, hd, aw, ad, "R10");
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule